// File: doc/BRIEF.md
# Eight-Channel Output-Compare Timer

This block is an output-compare timer. A free-running 16-bit counter is compared every cycle against eight 16-bit compare registers. When a running counter equals a channel's compare value, that channel's event flag is raised and an optional pin action takes place: toggle, drive low or drive high. The counter raises its own overflow flag when it wraps. Software reaches every register through a byte-wide bus with separate read and write strobes. Writes are synchronous. Reads are combinational from the address.

Two mode inputs can freeze the timer. The first is a wait request and the second is a debug halt. Each has its own enable bit. The timer also has a fast-clear mode. In this mode, an ordinary access to a compare register or to the counter clears the matching flag as a side effect, so software does not need a separate clear sequence. The block drives eight pin values. Each pin's output enable is forced on whenever that channel has a pin action configured.

Top module: `oc_timer`

## Requirements
- R1: After reset the following values hold:
  - The counter, both action registers, the mode register, the mask register, all flags and all pins are 0.
  - Every compare register is 0xFFFF.
- R2: The byte register map is as follows:
  - 0x00 is the counter high byte and 0x01 is the counter low byte. Both are readable and writable.
  - 0x02 is action register A and 0x03 is action register B.
  - 0x04 is the mode register.
  - 0x05 is the action mask.
  - 0x06 holds the channel flags, with bit n for channel n.
  - 0x07 holds the overflow flag in bit 0.
  - 0x10+2n is the high byte of channel n's compare register and 0x11+2n is its low byte.
  - The counter adds 1 on each running cycle, and a byte written to it takes effect at the write edge.
- R3: When mode bit 0 (wait-stop) is 1 and `wait_i` is high, the counter holds and no compare can succeed. When that bit is 0, the timer keeps running while `wait_i` is high.
- R4: When mode bit 1 (debug-stop) is 1 and `dbg_halt_i` is high, the counter holds and no compare can succeed. When that bit is 0, the timer keeps running while `dbg_halt_i` is high.
- R5: A compare succeeds on a running cycle in which the counter equals the channel's compare register. The channel flag is set at the following edge.
- R6: On a successful compare, the channel's {mode,level} pair selects the pin action:
  - 00 leaves the pin unchanged.
  - 01 toggles the pin.
  - 10 drives the pin to 0.
  - 11 drives the pin to 1.
- R7: The action register bits are packed as follows:
  - Action register A holds channels 7..4 and action register B holds channels 3..0, with the highest channel in the top two bits.
  - In each pair, the mode bit sits above the level bit. For example, channel 0 uses bits 1:0 of register B, with mode in bit 1.
  - Both action registers read back what was written.
- R8: `pin_oe_o[n]` is 1 whenever channel n's mode or level bit is 1. Otherwise it follows `dir_i[n]`.
- R9: When bit n of the action mask is 1, a successful compare on channel n sets its flag but leaves the pin unchanged.
- R10: Writing 1 to a flag bit clears that flag. Writing 0 leaves it unchanged. With fast-clear off (mode bit 2 = 0), accesses to the counter or the compare registers leave all flags unchanged.
- R11: With fast-clear on, a write to either byte of channel n's compare register clears flag n. A read of the compare register does not clear it.
- R12: With fast-clear on, a read or a write of either counter byte clears the overflow flag.
- R13: The overflow flag is set at the edge where a running counter wraps from 0xFFFF to 0x0000. When a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register byte address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe (used only for side-effect clears) |
| rdata_o | output | 8 | Read data for `addr_i` |
| wait_i | input | 1 | Wait-mode request |
| dbg_halt_i | input | 1 | Debug-halt request |
| dir_i | input | 8 | Direction bits used when no action is configured |
| pin_o | output | 8 | Compare-driven pin values |
| pin_oe_o | output | 8 | Pin output enables |

## Verification
The bench freezes the counter, loads exact values, and then releases it for a known number of cycles, so that every compare and every wrap lands on a cycle it can predict.

It targets the following corner cases:
- **Action decoding and packing.** All four action codes are exercised, together with packing in both action registers. A swapped pair, or a swapped mode/level order, would show up as wrong pin values.
- **Masked channel.** A masked channel must still raise its flag. A design that gated the flag with the mask would fail here.
- **Clear-versus-set collision.** The overflow flag is cleared explicitly in the same cycle as a wrap. A design that let the clear win would read 0.
- **Fast-clear side effects.** These are checked in both directions: a read of a compare register must not clear, and counter access with fast-clear off must not clear. Either fault would wipe flags early.
- **Freeze conditions.** A compare value that equals the frozen count must not fire. With each stop-enable bit cleared, the counter must advance by exactly the number of cycles the mode input was held.

// File: rtl/oct_pkg.sv
package oct_pkg;
  localparam int NCH = 8;
  localparam int CW  = 16;
  localparam int CHW = $clog2(NCH);
  localparam int AW  = CHW + 2;
  localparam int NCTRL = NCH / 4;

  localparam logic [AW-1:0] A_CNT_HI = AW'(0);
  localparam logic [AW-1:0] A_CNT_LO = AW'(1);
  localparam logic [AW-1:0] A_ACT_A  = AW'(2);
  localparam logic [AW-1:0] A_ACT_B  = AW'(3);
  localparam logic [AW-1:0] A_MODE   = AW'(4);
  localparam logic [AW-1:0] A_MASK   = AW'(5);
  localparam logic [AW-1:0] A_FLAG   = AW'(6);
  localparam logic [AW-1:0] A_OVF    = AW'(7);

  typedef struct packed {
    logic fast_clr;
    logic dbg_stop;
    logic wait_stop;
  } mode_t;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_TOG  = 2'b01,
    ACT_LOW  = 2'b10,
    ACT_HIGH = 2'b11
  } act_e;
endpackage

// File: rtl/oct_counter.sv
module oct_counter #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          wr_hi_i,
  input  logic          wr_lo_i,
  input  logic [7:0]    wdata_i,
  input  logic          ovf_clr_i,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_o
);
  localparam int LOW = CW - 8;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, wrap;

  assign wrap = run_i && (&cnt_q);

  always_comb begin
    cnt_d = run_i ? cnt_q + CW'(1) : cnt_q;
    if (wr_hi_i) cnt_d[CW-1:LOW] = wdata_i;
    if (wr_lo_i) cnt_d[LOW-1:0]  = wdata_i[LOW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= wrap | (ovf_q & ~ovf_clr_i);
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  assert_freeze_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_hi_i && !wr_lo_i) |=> $stable(cnt_q));

  assert_wrap_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && (&cnt_q) && !wr_hi_i && !wr_lo_i) |=> (ovf_q && cnt_q == '0));
endmodule

// File: rtl/oct_channel.sv
module oct_channel #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          wr_hi_i,
  input  logic          wr_lo_i,
  input  logic [7:0]    wdata_i,
  input  logic          mode_i,
  input  logic          level_i,
  input  logic          mask_i,
  input  logic          flag_clr_i,
  output logic [CW-1:0] cmp_o,
  output logic          flag_o,
  output logic          pin_o,
  output logic          oe_force_o
);
  import oct_pkg::*;
  localparam int LOW = CW - 8;

  logic [CW-1:0] cmp_q;
  logic          flag_q, pin_q, hit;
  act_e          act;

  assign hit = run_i && (cnt_i == cmp_q);
  assign act = act_e'({mode_i, level_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '1;
      flag_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      if (wr_hi_i) cmp_q[CW-1:LOW] <= wdata_i;
      if (wr_lo_i) cmp_q[LOW-1:0]  <= wdata_i[LOW-1:0];
      flag_q <= hit | (flag_q & ~flag_clr_i);
      if (hit && !mask_i) begin
        unique case (act)
          ACT_TOG:  pin_q <= ~pin_q;
          ACT_LOW:  pin_q <= 1'b0;
          ACT_HIGH: pin_q <= 1'b1;
          default:  pin_q <= pin_q;
        endcase
      end
    end
  end

  assign cmp_o      = cmp_q;
  assign flag_o     = flag_q;
  assign pin_o      = pin_q;
  assign oe_force_o = mode_i | level_i;

  assert_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_i == cmp_q) |=> flag_q);

  assert_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_i |=> $stable(pin_q));

  assert_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !(run_i && cnt_i == cmp_q)) |=> !flag_q);
endmodule

// File: rtl/oct_regs.sv
module oct_regs
  import oct_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [AW-1:0]          addr_i,
  input  logic [7:0]             wdata_i,
  input  logic                   we_i,
  input  logic                   re_i,
  input  logic [CW-1:0]          cnt_i,
  input  logic                   ovf_i,
  input  logic [NCH-1:0]         flag_i,
  input  logic [NCH-1:0][CW-1:0] cmp_i,
  output logic [7:0]             rdata_o,
  output mode_t                  mode_o,
  output logic [NCH-1:0]         mask_o,
  output logic [NCH-1:0]         om_o,
  output logic [NCH-1:0]         ol_o,
  output logic                   cnt_wr_hi_o,
  output logic                   cnt_wr_lo_o,
  output logic [NCH-1:0]         cmp_wr_hi_o,
  output logic [NCH-1:0]         cmp_wr_lo_o,
  output logic [NCH-1:0]         flag_clr_o,
  output logic                   ovf_clr_o
);
  localparam int LOW = CW - 8;

  logic [NCTRL-1:0][7:0] act_q;
  mode_t                 mode_q;
  logic [NCH-1:0]        mask_q;
  logic                  in_cmp, cnt_acc;
  logic [CHW-1:0]        ch_sel;

  assign in_cmp  = addr_i[AW-1];
  assign ch_sel  = addr_i[CHW:1];
  assign cnt_acc = (we_i | re_i) && (addr_i == A_CNT_HI || addr_i == A_CNT_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      mode_q <= '0;
      mask_q <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        A_ACT_A: act_q[0] <= wdata_i;
        A_ACT_B: act_q[1] <= wdata_i;
        A_MODE:  mode_q   <= mode_t'(wdata_i[2:0]);
        A_MASK:  mask_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  // channel n: register (NCTRL-1 - n/4), pair at bits 2*(n%4)+1 : 2*(n%4)
  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam int RIDX = NCTRL - 1 - n / 4;
    localparam int POS  = 2 * (n % 4);
    logic cmp_hit;
    assign cmp_hit        = we_i && in_cmp && (ch_sel == CHW'(n));
    assign om_o[n]        = act_q[RIDX][POS+1];
    assign ol_o[n]        = act_q[RIDX][POS];
    assign cmp_wr_hi_o[n] = cmp_hit && !addr_i[0];
    assign cmp_wr_lo_o[n] = cmp_hit &&  addr_i[0];
    assign flag_clr_o[n]  = (we_i && addr_i == A_FLAG && wdata_i[n])
                          || (mode_q.fast_clr && cmp_hit);
  end

  assign cnt_wr_hi_o = we_i && addr_i == A_CNT_HI;
  assign cnt_wr_lo_o = we_i && addr_i == A_CNT_LO;
  assign ovf_clr_o   = (we_i && addr_i == A_OVF && wdata_i[0])
                     || (mode_q.fast_clr && cnt_acc);

  always_comb begin
    rdata_o = '0;
    if (in_cmp) begin
      rdata_o = addr_i[0] ? cmp_i[ch_sel][LOW-1:0] : cmp_i[ch_sel][CW-1:LOW];
    end else begin
      unique case (addr_i)
        A_CNT_HI: rdata_o = cnt_i[CW-1:LOW];
        A_CNT_LO: rdata_o = cnt_i[LOW-1:0];
        A_ACT_A:  rdata_o = act_q[0];
        A_ACT_B:  rdata_o = act_q[1];
        A_MODE:   rdata_o = {5'b0, mode_q};
        A_MASK:   rdata_o = mask_q;
        A_FLAG:   rdata_o = flag_i;
        A_OVF:    rdata_o = {7'b0, ovf_i};
        default:  rdata_o = '0;
      endcase
    end
  end

  assign mode_o = mode_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/oc_timer.sv
module oc_timer
  import oct_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  addr_i,
  input  logic [7:0]     wdata_i,
  input  logic           we_i,
  input  logic           re_i,
  output logic [7:0]     rdata_o,
  input  logic           wait_i,
  input  logic           dbg_halt_i,
  input  logic [NCH-1:0] dir_i,
  output logic [NCH-1:0] pin_o,
  output logic [NCH-1:0] pin_oe_o
);
  mode_t                  mode;
  logic [NCH-1:0]         mask, om, ol, cmp_wr_hi, cmp_wr_lo, flag_clr, flags, oe_force;
  logic [NCH-1:0][CW-1:0] cmp;
  logic [CW-1:0]          cnt;
  logic                   run, ovf, ovf_clr, cnt_wr_hi, cnt_wr_lo;

  assign run = !((mode.wait_stop && wait_i) || (mode.dbg_stop && dbg_halt_i));

  oct_regs u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .re_i,
    .cnt_i(cnt), .ovf_i(ovf), .flag_i(flags), .cmp_i(cmp),
    .rdata_o, .mode_o(mode), .mask_o(mask), .om_o(om), .ol_o(ol),
    .cnt_wr_hi_o(cnt_wr_hi), .cnt_wr_lo_o(cnt_wr_lo),
    .cmp_wr_hi_o(cmp_wr_hi), .cmp_wr_lo_o(cmp_wr_lo),
    .flag_clr_o(flag_clr), .ovf_clr_o(ovf_clr)
  );

  oct_counter #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni, .run_i(run), .wr_hi_i(cnt_wr_hi), .wr_lo_i(cnt_wr_lo),
    .wdata_i, .ovf_clr_i(ovf_clr), .cnt_o(cnt), .ovf_o(ovf)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    oct_channel #(.CW(CW)) u_ch (
      .clk_i, .rst_ni, .run_i(run), .cnt_i(cnt),
      .wr_hi_i(cmp_wr_hi[n]), .wr_lo_i(cmp_wr_lo[n]), .wdata_i,
      .mode_i(om[n]), .level_i(ol[n]), .mask_i(mask[n]),
      .flag_clr_i(flag_clr[n]), .cmp_o(cmp[n]), .flag_o(flags[n]),
      .pin_o(pin_o[n]), .oe_force_o(oe_force[n])
    );
  end

  assign pin_oe_o = oe_force | dir_i;

  assert_fast_cnt_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode.fast_clr && (we_i || re_i) && (addr_i == A_CNT_HI || addr_i == A_CNT_LO)
     && !(run && (&cnt))) |=> !ovf);

  assert_wait_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode.wait_stop && wait_i && !cnt_wr_hi && !cnt_wr_lo) |=> $stable(cnt));

  assert_dbg_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode.dbg_stop && dbg_halt_i && !cnt_wr_hi && !cnt_wr_lo) |=> $stable(cnt));
endmodule

// File: tb/oc_timer_bench.sv
module oc_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0, re = 1'b0;
  logic [7:0] rdata;
  logic       wait_in = 1'b0, dbg_in = 1'b1;
  logic [7:0] dir = '0, pin, pin_oe;
  logic       probe = 1'b0;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  typedef struct {
    bit         is_pin;
    logic [7:0] exp;
    logic [7:0] exp_oe;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  oc_timer u_oc_timer (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .re_i(re), .rdata_o(rdata), .wait_i(wait_in), .dbg_halt_i(dbg_in),
    .dir_i(dir), .pin_o(pin), .pin_oe_o(pin_oe)
  );

  // monitor: pops and compares at the falling edge while a probe is active
  always @(negedge clk) begin
    if (probe && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (it.is_pin) begin
        if (pin !== it.exp || pin_oe !== it.exp_oe) begin
          n_bad++;
          $display("FAIL %s: pin=%h oe=%h expected pin=%h oe=%h",
                   it.tag, pin, pin_oe, it.exp, it.exp_oe);
        end
      end else if (rdata !== it.exp) begin
        n_bad++;
        $display("FAIL %s: read %h expected %h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(posedge clk); #1 addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.is_pin = 1'b0; it.exp = e; it.exp_oe = '0; it.tag = tag;
    @(posedge clk); #1 addr = a; re = 1'b1; probe = 1'b1; sb_q.push_back(it);
    @(posedge clk); #1 re = 1'b0; probe = 1'b0;
  endtask

  task automatic pins(input logic [7:0] p, input logic [7:0] oe, input string tag);
    item_t it;
    it.is_pin = 1'b1; it.exp = p; it.exp_oe = oe; it.tag = tag;
    @(posedge clk); #1 probe = 1'b1; sb_q.push_back(it);
    @(posedge clk); #1 probe = 1'b0;
  endtask

  // release the debug halt for exactly n running edges
  task automatic run_dbg(input int n);
    @(posedge clk); #1 dbg_in = 1'b0;
    repeat (n) @(posedge clk);
    #1 dbg_in = 1'b1;
  endtask

  task automatic set_cnt(input logic [15:0] v);
    wr(5'h00, v[15:8]); wr(5'h01, v[7:0]);
  endtask

  task automatic set_cmp(input int ch, input logic [15:0] v);
    wr(5'(5'h10 + 2 * ch), v[15:8]); wr(5'(5'h11 + 2 * ch), v[7:0]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(5'h02, 8'h00, "R1 action A");
    rd(5'h03, 8'h00, "R1 action B");
    rd(5'h06, 8'h00, "R1 flags");
    rd(5'h07, 8'h00, "R1 overflow");
    rd(5'h10, 8'hFF, "R1 compare reset");
    pins(8'h00, 8'h00, "R1 pins");

    wr(5'h04, 8'h02);  // debug-stop on, halt already high
    wr(5'h06, 8'hFF);
    wr(5'h07, 8'h01);
    set_cnt(16'h0010);
    set_cmp(0, 16'h0012);
    set_cmp(1, 16'h0013);
    set_cmp(2, 16'h0014);
    set_cmp(3, 16'h0013);
    wr(5'h03, 8'hE7);  // ch3=11 ch2=10 ch1=01 ch0=11
    wr(5'h05, 8'h08);
    dir = 8'h80;
    pins(8'h00, 8'h8F, "R8 forced enables with dir");
    rd(5'h06, 8'h00, "R4 frozen no compare");
    run_dbg(5);
    rd(5'h01, 8'h15, "R2 count low after 5 runs");
    rd(5'h00, 8'h00, "R2 count high");
    pins(8'h03, 8'h8F, "R6 R9 run1 pin actions");
    rd(5'h06, 8'h0F, "R5 R9 run1 flags");

    // explicit clear, fast-clear off
    wr(5'h10, 8'h00);
    rd(5'h06, 8'h0F, "R10 compare write no clear when fast off");
    wr(5'h06, 8'h01);
    rd(5'h06, 8'h0E, "R10 write-1 clear");
    wr(5'h06, 8'h00);
    rd(5'h06, 8'h0E, "R10 write-0 no effect");

    // fast-clear on
    wr(5'h04, 8'h06);
    wr(5'h13, 8'h13);
    rd(5'h06, 8'h0C, "R11 compare write clears flag1");
    rd(5'h15, 8'h14, "R2 compare2 low readback");
    rd(5'h06, 8'h0C, "R11 compare read no clear");

    // run 2: other codes and register A packing
    set_cnt(16'h0010);
    wr(5'h03, 8'hF6);  // ch3=11 ch2=11 ch1=01 ch0=10
    wr(5'h02, 8'hC0);  // ch7=11
    set_cmp(7, 16'h0011);
    dir = 8'h00;
    run_dbg(5);
    pins(8'h84, 8'h8F, "R6 R7 run2 pin actions");
    rd(5'h06, 8'h8F, "R5 run2 flags");
    rd(5'h02, 8'hC0, "R7 action A readback");

    // overflow, set beats clear
    wr(5'h04, 8'h02);
    set_cnt(16'hFFFF);
    rd(5'h07, 8'h00, "R13 no overflow before wrap");
    @(posedge clk); #1 dbg_in = 1'b0; addr = 5'h07; wdata = 8'h01; we = 1'b1;
    @(posedge clk); #1 dbg_in = 1'b1; we = 1'b0;
    rd(5'h07, 8'h01, "R13 set wins over clear");
    rd(5'h00, 8'h00, "R2 wrap high");
    rd(5'h01, 8'h00, "R2 wrap low");
    rd(5'h07, 8'h01, "R10 counter read no clear when fast off");
    wr(5'h04, 8'h06);
    rd(5'h00, 8'h00, "R12 fast counter read");
    rd(5'h07, 8'h00, "R12 overflow cleared by read");

    wr(5'h04, 8'h02);
    set_cnt(16'hFFFF);
    run_dbg(1);
    rd(5'h07, 8'h01, "R13 overflow on wrap");
    wr(5'h04, 8'h06);
    wr(5'h01, 8'h00);
    rd(5'h07, 8'h00, "R12 overflow cleared by counter write");
    wr(5'h04, 8'h02);
    set_cnt(16'hFFFF);
    run_dbg(1);
    wr(5'h07, 8'h01);
    rd(5'h07, 8'h00, "R10 overflow write-1 clear");

    // wait freeze
    wr(5'h06, 8'hFF);
    set_cnt(16'h0040);
    set_cmp(4, 16'h0040);
    wr(5'h04, 8'h03);
    @(posedge clk); #1 wait_in = 1'b1; dbg_in = 1'b0;
    repeat (6) @(posedge clk);
    rd(5'h01, 8'h40, "R3 wait freezes counter");
    rd(5'h06, 8'h00, "R3 wait blocks compare");
    #1 dbg_in = 1'b1;
    wr(5'h04, 8'h02);
    run_dbg(3);
    rd(5'h01, 8'h43, "R3 wait ignored when disabled");
    rd(5'h06, 8'h10, "R5 compare after release");

    // debug halt ignored when its enable is 0
    wr(5'h04, 8'h01);
    wr(5'h01, 8'h80);
    @(posedge clk); #1 wait_in = 1'b0;
    repeat (4) @(posedge clk);
    #1 wait_in = 1'b1;
    rd(5'h01, 8'h84, "R4 debug halt ignored when disabled");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run incomplete, expected completion");
      end
    join_any
    #5;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule